// File: doc/BRIEF.md
# Cyclic Sense Wake-up Sequencer

This block polls a group of switch inputs at intervals while the chip sits in low power. Keeping the switch pull-up supply on all the time would draw external current, so the sequencer turns one of two high-side supply outputs on only for a short window near the end of each cycle. It captures the enabled sense pins in the last tick of that window and compares the capture with the one from the previous sense event. A difference raises a cyclic-sense wake request. The same cycle timer also drives a periodic forced wake request, which takes priority when both occur at the same event.

A 3-bit select field sets the cycle period in base ticks, and a zero code switches the function off. A qualifying strobe `tick_i` marks each base tick. An on-time field sets how many ticks the supply stays on before the sample, and a 1-bit select picks which of the two outputs is pulsed. Outside low power the high-side outputs simply follow the normal control inputs. Inside low power those inputs are ignored and the sequencer alone drives the outputs.

Top module: `cyc_sense_seq`

## Requirements
- R1: While `lp_mode_i` is low, and right after reset, `hs_o` equals `hs_norm_i`, both wake outputs are low, and the timer and reference capture are held cleared.
- R2: While `lp_mode_i` is high and `cfg_sel_i` is 0, both bits of `hs_o` are low whatever `hs_norm_i` is, and no wake request is raised.
- R3: With `lp_mode_i` high and `cfg_sel_i` = s (1..7), a sense event occurs every 2^(s+PERIOD_SHIFT) base ticks (default PERIOD_SHIFT = 3). Only clock cycles with `tick_i` high count as ticks. The first event comes that many ticks after low-power entry.
- R4: Within each period the selected output is high during the last N ticks, where N is `cfg_on_ticks_i` and 0 counts as 1. If N reaches the period, the output stays on for the whole period. `cfg_hs_sel_i` = 0 selects `hs_o[0]` and 1 selects `hs_o[1]`. The other bit stays low.
- R5: The sample is `pins_i & cfg_pin_en_i`, taken at the last tick of the period. The first event after entering low power (or after `cfg_sel_i` leaves 0) only stores the reference and raises no cyclic-sense wake.
- R6: When forced wake is disabled, `wake_cs_o` pulses high for one clock, one clock after an event whose masked sample differs from the previous event's sample. A pin whose `cfg_pin_en_i` bit is 0 never causes a wake.
- R7: A pin change that reverts before the next event is not seen.
- R8: When `cfg_force_en_i` is high at an event, `wake_force_o` pulses one clock after every event, including the first after entry. `wake_cs_o` stays low even if the sample changed. The two wake outputs are never high together.
- R9: Leaving low power clears the timer and the reference. On re-entry the first event is again a reference-only load, even if the pins differ from the sample taken before the exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_mode_i | input | 1 | High while the chip is in low power |
| tick_i | input | 1 | Base tick strobe; qualifies timer advance |
| cfg_sel_i | input | 3 | Cycle period select; 0 disables sensing |
| cfg_on_ticks_i | input | ON_W | High-side on-time in ticks before the sample (0 treated as 1) |
| cfg_hs_sel_i | input | 1 | Which high-side output to pulse (0: bit 0, 1: bit 1) |
| cfg_pin_en_i | input | NUM_PINS | Per-pin sense enable mask |
| cfg_force_en_i | input | 1 | Enable the periodic forced wake |
| hs_norm_i | input | 2 | Normal high-side control, used outside low power |
| pins_i | input | NUM_PINS | Switch sense inputs |
| hs_o | output | 2 | High-side output enables |
| wake_cs_o | output | 1 | Cyclic-sense wake request pulse |
| wake_force_o | output | 1 | Forced wake request pulse |

## Verification
The bench builds the block with PERIOD_SHIFT = 1, six pins and a 4-bit on-time field. Select codes 1 and 2 then give periods of 4 and 8 ticks, so one run can cover many sense events, several re-entries into low power, and an on-time that exceeds the whole period. With alternating tick strobes the event spacing doubles in clock cycles, which shows that only qualified ticks advance the timer. Each event's expected outcome (none, cyclic or forced) is queued with the exact cycle it should appear on. The high-side outputs are compared on every clock cycle.

// File: rtl/cs_pkg.sv
package cs_pkg;
    localparam int SEL_W = 3;
    localparam int HS_N  = 2;

    typedef enum logic [1:0] {
        WK_NONE   = 2'd0,
        WK_CYCLIC = 2'd1,
        WK_FORCED = 2'd2
    } wake_kind_e;

    // Period length in base ticks for a given select code.
    function automatic int period_ticks(input logic [SEL_W-1:0] sel, input int shift);
        return 1 << (int'(sel) + shift);
    endfunction
endpackage

// File: rtl/cs_timer.sv
module cs_timer
    import cs_pkg::*;
#(
    parameter int PERIOD_SHIFT = 3,
    parameter int ON_W         = 4,
    localparam int CNT_W       = (1 << SEL_W) - 1 + PERIOD_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [ON_W-1:0]  on_ticks_i,
    output logic             event_o,
    output logic             window_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    int   period;
    int   pos;
    int   on_eff;

    always_comb begin
        period   = period_ticks(sel_i, PERIOD_SHIFT);
        pos      = int'(st_q.cnt);
        on_eff   = (on_ticks_i == '0) ? 1 : int'(on_ticks_i);
        event_o  = run_i && tick_i && (pos >= period - 1);
        window_o = run_i && ((pos + on_eff) >= period);

        st_d = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = event_o ? '0 : st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cs_compare.sv
module cs_compare #(
    parameter int NUM_PINS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                event_i,
    input  logic [NUM_PINS-1:0] sample_i,
    output logic                change_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] ref_smp;
        logic                valid;
    } cmp_t;

    cmp_t st_d, st_q;

    always_comb begin
        change_o = event_i && st_q.valid && (sample_i != st_q.ref_smp);

        st_d = st_q;
        if (!run_i) begin
            st_d.ref_smp = '0;
            st_d.valid   = 1'b0;
        end else if (event_i) begin
            st_d.ref_smp = sample_i;
            st_d.valid   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cs_hs_drive.sv
module cs_hs_drive
    import cs_pkg::*;
(
    input  logic            lp_i,
    input  logic            active_i,
    input  logic            sel_i,
    input  logic [HS_N-1:0] norm_i,
    output logic [HS_N-1:0] hs_o
);
    for (genvar g = 0; g < HS_N; g++) begin : g_out
        assign hs_o[g] = lp_i ? (active_i && (int'(sel_i) == g)) : norm_i[g];
    end
endmodule

// File: rtl/cyc_sense_seq.sv
module cyc_sense_seq
    import cs_pkg::*;
#(
    parameter int NUM_PINS     = 6,
    parameter int ON_W         = 4,
    parameter int PERIOD_SHIFT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lp_mode_i,
    input  logic                tick_i,
    input  logic [SEL_W-1:0]    cfg_sel_i,
    input  logic [ON_W-1:0]     cfg_on_ticks_i,
    input  logic                cfg_hs_sel_i,
    input  logic [NUM_PINS-1:0] cfg_pin_en_i,
    input  logic                cfg_force_en_i,
    input  logic [HS_N-1:0]     hs_norm_i,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [HS_N-1:0]     hs_o,
    output logic                wake_cs_o,
    output logic                wake_force_o
);
    typedef struct packed {
        wake_kind_e kind;
    } top_t;

    logic run;
    logic evt;
    logic window;
    logic change;
    logic [NUM_PINS-1:0] sample;
    top_t st_d, st_q;

    assign run    = lp_mode_i && (cfg_sel_i != '0);
    assign sample = pins_i & cfg_pin_en_i;

    cs_timer #(
        .PERIOD_SHIFT (PERIOD_SHIFT),
        .ON_W         (ON_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .tick_i     (tick_i),
        .sel_i      (cfg_sel_i),
        .on_ticks_i (cfg_on_ticks_i),
        .event_o    (evt),
        .window_o   (window)
    );

    cs_compare #(
        .NUM_PINS (NUM_PINS)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .event_i  (evt),
        .sample_i (sample),
        .change_o (change)
    );

    cs_hs_drive u_hs (
        .lp_i     (lp_mode_i),
        .active_i (window),
        .sel_i    (cfg_hs_sel_i),
        .norm_i   (hs_norm_i),
        .hs_o     (hs_o)
    );

    // Forced wake outranks a simultaneous pin change.
    always_comb begin
        st_d.kind = WK_NONE;
        if (evt && cfg_force_en_i) st_d.kind = WK_FORCED;
        else if (change)           st_d.kind = WK_CYCLIC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{kind: WK_NONE};
        else        st_q <= st_d;
    end

    assign wake_cs_o    = (st_q.kind == WK_CYCLIC);
    assign wake_force_o = (st_q.kind == WK_FORCED);
endmodule

// File: rtl/cs_seq_chk.sv
module cs_seq_chk
    import cs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lp_mode_i,
    input logic [SEL_W-1:0] cfg_sel_i,
    input logic             cfg_force_en_i,
    input logic [HS_N-1:0]  hs_norm_i,
    input logic [HS_N-1:0]  hs_o,
    input logic             wake_cs_o,
    input logic             wake_force_o
);
    a_r1_norm_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_mode_i |-> (hs_o == hs_norm_i));

    a_r2_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode_i && cfg_sel_i == '0) |-> (hs_o == '0));

    a_r4_single_hs: assert property (@(posedge clk) disable iff (!rst_n)
        lp_mode_i |-> $onehot0(hs_o));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_cs_o && wake_force_o));

    a_r8_force_gated: assert property (@(posedge clk) disable iff (!rst_n)
        wake_force_o |-> $past(cfg_force_en_i));

    a_r8_cs_masked: assert property (@(posedge clk) disable iff (!rst_n)
        wake_cs_o |-> !$past(cfg_force_en_i));

    a_r9_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_cs_o || wake_force_o) |-> ($past(lp_mode_i) && $past(cfg_sel_i) != '0));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wake_cs_o |=> !wake_cs_o);
endmodule

bind cyc_sense_seq cs_seq_chk u_chk (.*);

// File: tb/cyc_sense_seq_tb.sv
module cyc_sense_seq_tb;
    localparam int NP = 6;
    localparam int OW = 4;
    localparam int SH = 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          lp = 1'b0;
    logic          tick = 1'b1;
    logic [2:0]    sel = '0;
    logic [OW-1:0] on_t = '0;
    logic          hsel = 1'b0;
    logic [NP-1:0] pen = '0;
    logic          fen = 1'b0;
    logic [1:0]    norm = 2'b00;
    logic [NP-1:0] pins = '0;
    logic [1:0]    hs;
    logic          wcs, wfo;

    cyc_sense_seq #(.NUM_PINS(NP), .ON_W(OW), .PERIOD_SHIFT(SH)) u_dut (
        .clk(clk), .rst_n(rst_n), .lp_mode_i(lp), .tick_i(tick),
        .cfg_sel_i(sel), .cfg_on_ticks_i(on_t), .cfg_hs_sel_i(hsel),
        .cfg_pin_en_i(pen), .cfg_force_en_i(fen), .hs_norm_i(norm),
        .pins_i(pins), .hs_o(hs), .wake_cs_o(wcs), .wake_force_o(wfo)
    );

    typedef struct {
        int         due;
        logic [1:0] kind;   // {cyclic, forced}
        string      req;
    } exp_t;

    exp_t q[$];
    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    int            pos = 0;
    logic [NP-1:0] mref = '0;
    bit            mvalid = 0;
    string         cur_req = "R5";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pops each expected event outcome on its due cycle.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                check(e.req, {30'd0, wcs, wfo}, {30'd0, e.kind});
            end else if (wcs || wfo) begin
                check("R9 spurious wake", {30'd0, wcs, wfo}, 32'd0);
            end
        end
    end

    // One clock step: predicts any event at the coming edge, then checks hs_o.
    task automatic tick_once();
        int            p;
        int            neff;
        bit            run;
        logic [NP-1:0] smp;
        logic [1:0]    k;
        logic [1:0]    exp_hs;
        run  = lp && (sel != 0);
        p    = 1 << (int'(sel) + SH);
        neff = (on_t == 0) ? 1 : int'(on_t);
        if (!run) begin
            pos    = 0;
            mvalid = 0;
        end else if (tick) begin
            if (pos == p - 1) begin
                smp = pins & pen;
                if (fen)                          k = 2'b01;
                else if (mvalid && smp != mref)   k = 2'b10;
                else                              k = 2'b00;
                q.push_back('{cyc + 1, k, cur_req});
                mref   = smp;
                mvalid = 1;
                pos    = 0;
            end else begin
                pos++;
            end
        end
        @(negedge clk);
        if (!lp) begin
            check("R1 hs follows normal", {30'd0, hs}, {30'd0, norm});
        end else if (!run) begin
            check("R2 hs off when disabled", {30'd0, hs}, 32'd0);
        end else begin
            exp_hs = ((pos + neff) >= p) ? (hsel ? 2'b10 : 2'b01) : 2'b00;
            check("R4 hs window", {30'd0, hs}, {30'd0, exp_hs});
        end
    endtask

    task automatic ticks(input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            tick = gap ? ~tick : 1'b1;
            tick_once();
        end
        tick = 1'b1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all) actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        norm = 2'b11;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        check("R1 reset hs", {30'd0, hs}, {30'd0, norm});
        check("R1 reset wake", {30'd0, wcs, wfo}, 32'd0);

        // R2: low power with sensing disabled
        lp = 1'b1; sel = 3'd0; cur_req = "R2";
        ticks(12, 0);

        // R5: first event loads only; then R6 changes
        sel = 3'd1; on_t = 4'd2; hsel = 1'b0; pen = 6'h3F; fen = 1'b0; pins = 6'h00;
        cur_req = "R5 first event";
        ticks(4, 0);
        cur_req = "R6 pin change";
        ticks(4, 0);
        pins = 6'h01;
        ticks(4, 0);
        ticks(4, 0);

        // R6: masked pin
        pen = 6'h3E;
        ticks(4, 0);
        cur_req = "R6 masked pin";
        pins = 6'h00;
        ticks(4, 0);
        pins = 6'h08;
        cur_req = "R6 enabled pin";
        ticks(4, 0);

        // R7: change that reverts between events
        cur_req = "R7 glitch";
        pins = 6'h0C;
        ticks(2, 0);
        pins = 6'h08;
        ticks(2, 0);

        // R4: other output, zero on-time, then on-time beyond period
        cur_req = "R4 event";
        sel = 3'd2; on_t = 4'd0; hsel = 1'b1; norm = 2'b01;
        ticks(16, 0);
        on_t = 4'd15;
        ticks(16, 0);

        // R3: gapped ticks double the period in clocks
        cur_req = "R3 gapped ticks";
        sel = 3'd1; on_t = 4'd1;
        ticks(16, 1);

        // R9: exit mid-period and re-enter with different pins
        pins = 6'h01;
        ticks(2, 0);
        lp = 1'b0; cur_req = "R9 exit";
        ticks(3, 0);
        pins = 6'h3E; lp = 1'b1; cur_req = "R9 re-entry";
        ticks(4, 0);
        ticks(4, 0);

        // R8: forced wake wins over pin change
        fen = 1'b1; cur_req = "R8 forced";
        ticks(4, 0);
        pins = 6'h00;
        ticks(4, 0);
        lp = 1'b0;
        ticks(2, 0);
        lp = 1'b1; pins = 6'h3E;
        ticks(4, 0);
        fen = 1'b0; cur_req = "R8 force off";
        ticks(4, 0);

        lp = 1'b0; cur_req = "R1 idle";
        ticks(4, 0);
        repeat (2) @(negedge clk);
        check("R6 no pending events", q.size(), 32'd0);

        done = 1;
        summary();
        $finish;
    end
endmodule